// File: doc/BRIEF.md
# SMBus Thermal Block-Write Command Decoder

This block sits behind an SMBus target interface that already handles bit-level signalling and address matching. The interface delivers each transaction as a start marker, a series of byte strobes with their data, and a stop marker. The decoder reads the stream in Block Write layout. The first byte is a command code that picks one of six thermal-management registers. The second byte is a byte count. The payload bytes follow.

Payload bytes shift into a shadow buffer. The chosen register is loaded from that buffer in one cycle, at the stop marker, and only if the command was known, the count matched the count that command requires, and exactly that many payload bytes arrived. Any other transaction is dropped and every register keeps its value. When the 48-bit status register is written and the interrupt enable is high, a one-cycle interrupt pulse goes to the host.

Top module: `thermwr_decoder`

## Requirements
- R1: After reset, every register output is zero and `irq_pulse` is low.
- R2: Command 41h with count 6 loads `status` from six payload bytes, most significant byte first (the first byte lands in bits 47:40, the last in bits 7:0).
- R3: Command 42h with count 4 loads the core limits in this order: `cpu_lo` high byte, `cpu_lo` low byte, `cpu_hi` high byte, `cpu_hi` low byte.
- R4: Commands 43h, 44h and 45h with count 2 load the memory/graphics, hub and DIMM limit pairs respectively. The first payload byte is the lower limit and the second is the upper limit.
- R5: Command 50h with count 2 loads the 16-bit `pwr_clamp`, high byte first.
- R6: A register changes only on the clock edge where `frm_stop` is sampled. The new value is visible from the following cycle, and no register changes while payload bytes are still arriving.
- R7: If fewer payload bytes than the required count arrive before the stop, the transaction is aborted and all registers are unchanged.
- R8: An unknown command code, or a count byte that differs from the count the command requires, aborts the transaction with no register update.
- R9: If more payload bytes than the required count arrive, the extra bytes are ignored and the whole transaction is aborted.
- R10: `irq_pulse` is high for exactly one cycle, in the cycle after the stop edge of a committed 41h write, if `irq_en` is high at that stop. No other command and no aborted write raises it.
- R11: Byte strobes received outside a start/stop frame are ignored. A new start in the middle of a transaction discards the partial transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en | input | 1 | Host interrupt enable for status writes |
| frm_start | input | 1 | Start marker, one cycle |
| frm_stop | input | 1 | Stop marker, one cycle |
| byte_vld | input | 1 | Byte strobe; `byte_data` is valid |
| byte_data | input | 8 | Received byte |
| status | output | 48 | Status register |
| cpu_lo | output | 16 | Core lower temperature limit |
| cpu_hi | output | 16 | Core upper temperature limit |
| mem_lo | output | 8 | Memory/graphics lower limit |
| mem_hi | output | 8 | Memory/graphics upper limit |
| hub_lo | output | 8 | Hub lower limit |
| hub_hi | output | 8 | Hub upper limit |
| dimm_lo | output | 8 | DIMM lower limit |
| dimm_hi | output | 8 | DIMM upper limit |
| pwr_clamp | output | 16 | Core power clamp |
| irq_pulse | output | 1 | Status-write interrupt pulse |

## Verification
The assertions check two things on every cycle. No register moves except on a stop edge. The interrupt is a single-cycle pulse that only follows a stop seen with the enable high. Whether the right register received the right bytes in the right order, and whether short, long, mis-counted, unknown or restarted transactions are dropped, depends on the whole transaction. Only the bench's directed and random scenarios can show that, by comparing against a model of the command map.

// File: rtl/thermwr_pkg.sv
package thermwr_pkg;
    localparam int MAX_LEN = 6;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    localparam logic [7:0] CODE_STS   = 8'h41;
    localparam logic [7:0] CODE_CPU   = 8'h42;
    localparam logic [7:0] CODE_MEM   = 8'h43;
    localparam logic [7:0] CODE_HUB   = 8'h44;
    localparam logic [7:0] CODE_DIMM  = 8'h45;
    localparam logic [7:0] CODE_CLAMP = 8'h50;

    typedef enum logic [2:0] {
        TGT_STS, TGT_CPU, TGT_MEM, TGT_HUB, TGT_DIMM, TGT_CLAMP
    } tgt_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_CMD, PH_CNT, PH_DATA, PH_DROP
    } phase_e;
endpackage

// File: rtl/thermwr_cmd_table.sv
module thermwr_cmd_table
    import thermwr_pkg::*;
(
    input  logic [7:0]       code,
    output logic             hit,
    output tgt_e             tgt,
    output logic [CNT_W-1:0] need
);
    always_comb begin
        hit  = 1'b1;
        tgt  = TGT_STS;
        need = CNT_W'(MAX_LEN);
        case (code)
            CODE_STS:   begin tgt = TGT_STS;   need = CNT_W'(6); end
            CODE_CPU:   begin tgt = TGT_CPU;   need = CNT_W'(4); end
            CODE_MEM:   begin tgt = TGT_MEM;   need = CNT_W'(2); end
            CODE_HUB:   begin tgt = TGT_HUB;   need = CNT_W'(2); end
            CODE_DIMM:  begin tgt = TGT_DIMM;  need = CNT_W'(2); end
            CODE_CLAMP: begin tgt = TGT_CLAMP; need = CNT_W'(2); end
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/thermwr_shadow.sv
module thermwr_shadow #(
    parameter int NBYTES = 6,
    localparam int W = 8 * NBYTES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic [7:0]   din,
    output logic [W-1:0] data
);
    logic [W-1:0] buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (shift_en) buf_d = {buf_q[W-9:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign data = buf_q;
endmodule

// File: rtl/thermwr_decoder.sv
module thermwr_decoder
    import thermwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        irq_en,
    input  logic        frm_start,
    input  logic        frm_stop,
    input  logic        byte_vld,
    input  logic [7:0]  byte_data,
    output logic [47:0] status,
    output logic [15:0] cpu_lo,
    output logic [15:0] cpu_hi,
    output logic [7:0]  mem_lo,
    output logic [7:0]  mem_hi,
    output logic [7:0]  hub_lo,
    output logic [7:0]  hub_hi,
    output logic [7:0]  dimm_lo,
    output logic [7:0]  dimm_hi,
    output logic [15:0] pwr_clamp,
    output logic        irq_pulse
);
    localparam int SH_W = 8 * MAX_LEN;

    typedef struct packed {
        phase_e           phase;
        tgt_e             tgt;
        logic [CNT_W-1:0] need;
        logic [CNT_W-1:0] got;
        logic [47:0]      sts;
        logic [15:0]      clo;
        logic [15:0]      chi;
        logic [7:0]       mlo;
        logic [7:0]       mhi;
        logic [7:0]       hlo;
        logic [7:0]       hhi;
        logic [7:0]       dlo;
        logic [7:0]       dhi;
        logic [15:0]      clamp;
        logic             irq;
    } st_t;

    st_t st_d, st_q;

    logic             lk_hit;
    tgt_e             lk_tgt;
    logic [CNT_W-1:0] lk_need;
    logic             shift_en;
    logic [SH_W-1:0]  sh;

    thermwr_cmd_table u_table (
        .code (byte_data),
        .hit  (lk_hit),
        .tgt  (lk_tgt),
        .need (lk_need)
    );

    thermwr_shadow #(.NBYTES(MAX_LEN)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (byte_data),
        .data     (sh)
    );

    assign shift_en = !frm_start && !frm_stop && byte_vld &&
                      (st_q.phase == PH_DATA) && (st_q.got != st_q.need);

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (frm_start) begin
            st_d.phase = PH_CMD;
            st_d.got   = '0;
        end else if (frm_stop) begin
            if (st_q.phase == PH_DATA && st_q.got == st_q.need) begin
                case (st_q.tgt)
                    TGT_STS: begin
                        st_d.sts = sh[47:0];
                        st_d.irq = irq_en;
                    end
                    TGT_CPU: begin
                        st_d.clo = sh[31:16];
                        st_d.chi = sh[15:0];
                    end
                    TGT_MEM:  begin st_d.mlo = sh[15:8]; st_d.mhi = sh[7:0]; end
                    TGT_HUB:  begin st_d.hlo = sh[15:8]; st_d.hhi = sh[7:0]; end
                    TGT_DIMM: begin st_d.dlo = sh[15:8]; st_d.dhi = sh[7:0]; end
                    default:  st_d.clamp = sh[15:0];
                endcase
            end
            st_d.phase = PH_IDLE;
        end else if (byte_vld) begin
            case (st_q.phase)
                PH_CMD: begin
                    if (lk_hit) begin
                        st_d.tgt   = lk_tgt;
                        st_d.need  = lk_need;
                        st_d.phase = PH_CNT;
                    end else begin
                        st_d.phase = PH_DROP;
                    end
                end
                PH_CNT: begin
                    if (byte_data == 8'(st_q.need)) st_d.phase = PH_DATA;
                    else                            st_d.phase = PH_DROP;
                end
                PH_DATA: begin
                    if (st_q.got == st_q.need) st_d.phase = PH_DROP;
                    else                       st_d.got   = st_q.got + 1'b1;
                end
                default: st_d.phase = st_q.phase;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign status    = st_q.sts;
    assign cpu_lo    = st_q.clo;
    assign cpu_hi    = st_q.chi;
    assign mem_lo    = st_q.mlo;
    assign mem_hi    = st_q.mhi;
    assign hub_lo    = st_q.hlo;
    assign hub_hi    = st_q.hhi;
    assign dimm_lo   = st_q.dlo;
    assign dimm_hi   = st_q.dhi;
    assign pwr_clamp = st_q.clamp;
    assign irq_pulse = st_q.irq;
endmodule

// File: rtl/thermwr_checker.sv
module thermwr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_en,
    input logic        frm_stop,
    input logic [47:0] status,
    input logic [15:0] cpu_lo,
    input logic [15:0] cpu_hi,
    input logic [7:0]  mem_lo,
    input logic [7:0]  mem_hi,
    input logic [7:0]  hub_lo,
    input logic [7:0]  hub_hi,
    input logic [7:0]  dimm_lo,
    input logic [7:0]  dimm_hi,
    input logic [15:0] pwr_clamp,
    input logic        irq_pulse
);
    AST_IRQ_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ($past(frm_stop) && $past(irq_en))); // R10
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse); // R10
    AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frm_stop) |-> $stable(status)); // R6
    AST_CPU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frm_stop) |-> ($stable(cpu_lo) && $stable(cpu_hi))); // R6
    AST_LIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frm_stop) |-> ($stable({mem_lo, mem_hi, hub_lo, hub_hi, dimm_lo, dimm_hi}))); // R6
    AST_CLAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frm_stop) |-> $stable(pwr_clamp)); // R6
endmodule

bind thermwr_decoder thermwr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_en    (irq_en),
    .frm_stop  (frm_stop),
    .status    (status),
    .cpu_lo    (cpu_lo),
    .cpu_hi    (cpu_hi),
    .mem_lo    (mem_lo),
    .mem_hi    (mem_hi),
    .hub_lo    (hub_lo),
    .hub_hi    (hub_hi),
    .dimm_lo   (dimm_lo),
    .dimm_hi   (dimm_hi),
    .pwr_clamp (pwr_clamp),
    .irq_pulse (irq_pulse)
);

// File: tb/thermwr_decoder_tb.sv
module thermwr_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_en = 1'b0;
    logic        frm_start = 1'b0;
    logic        frm_stop = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [47:0] status;
    logic [15:0] cpu_lo, cpu_hi, pwr_clamp;
    logic [7:0]  mem_lo, mem_hi, hub_lo, hub_hi, dimm_lo, dimm_hi;
    logic        irq_pulse;

    always #2.5 clk = ~clk;

    thermwr_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
        .frm_start(frm_start), .frm_stop(frm_stop),
        .byte_vld(byte_vld), .byte_data(byte_data),
        .status(status), .cpu_lo(cpu_lo), .cpu_hi(cpu_hi),
        .mem_lo(mem_lo), .mem_hi(mem_hi), .hub_lo(hub_lo), .hub_hi(hub_hi),
        .dimm_lo(dimm_lo), .dimm_hi(dimm_hi), .pwr_clamp(pwr_clamp),
        .irq_pulse(irq_pulse)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [47:0] e_sts;
    logic [15:0] e_clo, e_chi, e_clamp;
    logic [7:0]  e_mlo, e_mhi, e_hlo, e_hhi, e_dlo, e_dhi;
    logic [7:0]  pay [0:7];

    function automatic int req_len(input logic [7:0] c);
        case (c)
            8'h41: return 6;
            8'h42: return 4;
            8'h43, 8'h44, 8'h45, 8'h50: return 2;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " status"}, 64'(status), 64'(e_sts));
        chk({req, " cpu"}, {32'h0, cpu_lo, cpu_hi}, {32'h0, e_clo, e_chi});
        chk({req, " limits"}, {16'h0, mem_lo, mem_hi, hub_lo, hub_hi, dimm_lo, dimm_hi},
                              {16'h0, e_mlo, e_mhi, e_hlo, e_hhi, e_dlo, e_dhi});
        chk({req, " clamp"}, 64'(pwr_clamp), 64'(e_clamp));
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_vld  = 1'b1;
        byte_data = b;
        @(negedge clk);
        byte_vld  = 1'b0;
    endtask

    task automatic pulse_start();
        frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
    endtask

    // Full transaction: start, cmd, count, nb payload bytes from pay[], stop.
    task automatic run_txn(input logic [7:0] cmd, input logic [7:0] cnt,
                           input int nb, input bit ien, input string req);
        int  rl;
        bit  ok;
        irq_en = ien;
        pulse_start();
        send_byte(cmd);
        send_byte(cnt);
        for (int i = 0; i < nb; i++) send_byte(pay[i]);
        chk({req, " R6 pre-stop"}, 64'(status), 64'(e_sts));
        chk({req, " R6 pre-stop cpu"}, {32'h0, cpu_lo, cpu_hi}, {32'h0, e_clo, e_chi});
        frm_stop = 1'b1;
        @(negedge clk);
        frm_stop = 1'b0;
        rl = req_len(cmd);
        ok = (rl != 0) && (int'(cnt) == rl) && (nb == rl);
        if (ok) begin
            case (cmd)
                8'h41: e_sts = {pay[0], pay[1], pay[2], pay[3], pay[4], pay[5]};
                8'h42: begin e_clo = {pay[0], pay[1]}; e_chi = {pay[2], pay[3]}; end
                8'h43: begin e_mlo = pay[0]; e_mhi = pay[1]; end
                8'h44: begin e_hlo = pay[0]; e_hhi = pay[1]; end
                8'h45: begin e_dlo = pay[0]; e_dhi = pay[1]; end
                default: e_clamp = {pay[0], pay[1]};
            endcase
        end
        chk({req, " R10 irq"}, 64'(irq_pulse), 64'(ok && cmd == 8'h41 && ien));
        chk_all(req);
        @(negedge clk);
        chk({req, " R10 irq width"}, 64'(irq_pulse), 64'h0);
    endtask

    task automatic fill_pay();
        for (int i = 0; i < 8; i++) pay[i] = 8'($urandom);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] cmds [0:6];
        void'($urandom(32'd20240611));
        cmds = '{8'h41, 8'h42, 8'h43, 8'h44, 8'h45, 8'h50, 8'h00};
        e_sts = '0; e_clo = '0; e_chi = '0; e_clamp = '0;
        e_mlo = '0; e_mhi = '0; e_hlo = '0; e_hhi = '0; e_dlo = '0; e_dhi = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 reset");
        chk("R1 reset irq", 64'(irq_pulse), 64'h0);

        pay = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6, 8'h00, 8'h00};
        run_txn(8'h41, 8'd6, 6, 1'b1, "R2 status ien=1");
        chk("R2 byte order", 64'(status), 64'h0000A1B2C3D4E5F6);
        pay = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h00, 8'h00};
        run_txn(8'h41, 8'd6, 6, 1'b0, "R10 status ien=0");

        pay = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h00, 8'h00, 8'h00, 8'h00};
        run_txn(8'h42, 8'd4, 4, 1'b1, "R3 cpu");
        chk("R3 cpu_lo", 64'(cpu_lo), 64'h1234);
        pay[0] = 8'h0A; pay[1] = 8'h5F;
        run_txn(8'h43, 8'd2, 2, 1'b1, "R4 mem");
        pay[0] = 8'h1B; pay[1] = 8'h6E;
        run_txn(8'h44, 8'd2, 2, 1'b1, "R4 hub");
        pay[0] = 8'h2C; pay[1] = 8'h7D;
        run_txn(8'h45, 8'd2, 2, 1'b1, "R4 dimm");
        chk("R4 dimm order", {56'h0, dimm_lo}, 64'h2C);
        pay[0] = 8'hBE; pay[1] = 8'hEF;
        run_txn(8'h50, 8'd2, 2, 1'b1, "R5 clamp");
        chk("R5 clamp order", 64'(pwr_clamp), 64'hBEEF);

        fill_pay();
        run_txn(8'h41, 8'd6, 5, 1'b1, "R7 short status");
        run_txn(8'h42, 8'd4, 3, 1'b1, "R7 short cpu");
        run_txn(8'h47, 8'd2, 2, 1'b1, "R8 unknown cmd");
        run_txn(8'h43, 8'd3, 2, 1'b1, "R8 count mismatch");
        run_txn(8'h50, 8'd4, 4, 1'b1, "R8 count mismatch full");
        run_txn(8'h44, 8'd2, 3, 1'b1, "R9 extra byte");
        run_txn(8'h41, 8'd6, 7, 1'b1, "R9 extra status");

        // R11: bytes with no start frame, then a stop
        irq_en = 1'b1;
        send_byte(8'h43); send_byte(8'h02); send_byte(8'h99); send_byte(8'h98);
        frm_stop = 1'b1; @(negedge clk); frm_stop = 1'b0;
        chk("R11 no-frame irq", 64'(irq_pulse), 64'h0);
        chk_all("R11 no-frame");
        // R11: restart in mid transaction
        pulse_start();
        send_byte(8'h42); send_byte(8'h04); send_byte(8'hDE); send_byte(8'hAD);
        pay[0] = 8'h3C; pay[1] = 8'h4D;
        run_txn(8'h43, 8'd2, 2, 1'b1, "R11 restart");

        for (int n = 0; n < 300; n++) begin
            logic [7:0] c, k;
            int nb, r;
            c = cmds[$urandom_range(0, 6)];
            if (c == 8'h00) c = 8'($urandom);
            r = req_len(c);
            k = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(0, 7)) : 8'(r);
            case ($urandom_range(0, 5))
                0: nb = (r > 0) ? r - 1 : 0;
                1: nb = r + 1;
                default: nb = r;
            endcase
            fill_pay();
            run_txn(c, k, nb, 1'($urandom), "R2 R3 R4 R5 R7 R8 R9 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule